// File: doc/BRIEF.md
# Dual-Length Pseudorandom Pattern Lock Monitor

The block watches a recovered serial bit stream, one bit per receive clock, and decides whether it carries a maximal-length pseudorandom test pattern. A rate-mode input selects the pattern. The short mode, used at the two faster line rates, uses a 15-stage pattern. The long mode, used at the remaining rate, uses a 23-stage pattern. While it has no lock, the monitor keeps hunting: it predicts each incoming bit from the bits it has already received and counts unbroken runs of correct predictions.

After a long enough run it declares lock and loads a local generator, which then runs free and supplies the expected sequence. A single status line reports both results. It stays high while the monitor has no lock. When lock is gained it goes low, and from then on it rises for exactly one clock after each received bit that disagrees with the generator. A burst of errors inside a sliding window drops lock and restarts the hunt. An enable input drives an output-enable, so the status pin can be left floating at the pad.

Top module: `prbs_lock_mon`

## Requirements
- R1: With mode_i=0 the expected bit is b[n] = b[n-15] XOR b[n-14] (x^15+x^14+1). With mode_i=1 it is b[n] = b[n-23] XOR b[n-18] (x^23+x^18+1).
- R2: Lock is declared after 32 consecutive received bits that match the prediction made from the preceding received bits. Lock is therefore never declared within the first 31 bits after reset, after a mode change or after a lock loss.
- R3: While not locked, stat_o is 1.
- R4: While locked, stat_o is 0, except that it is 1 for exactly the one clock after each received bit that differs from the generator. A single corrupted bit is flagged once.
- R5: Five errors inside any 64-bit window leave lock in place.
- R6: A sixth error inside any 64-bit window drops lock. stat_o then stays 1 and the hunt restarts.
- R7: A change of mode_i drops lock in the clock after the change, whatever else happens in that cycle.
- R8: A stream of all zeros is never reported as locked.
- R9: stat_oe_o equals en_i delayed by one clock and is 0 during reset.
- R10: During reset, stat_o is 1.
- R11: After a lock loss, the monitor locks again once a clean pattern resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock, one data bit per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Status output enable request |
| mode_i | input | 1 | Pattern select: 0 = 15-stage, 1 = 23-stage |
| rx_bit_i | input | 1 | Received data bit |
| stat_o | output | 1 | High when unlocked; one-clock pulse per bit error when locked |
| stat_oe_o | output | 1 | Output enable for the status pad |

## Verification
The per-bit error flag and the lock-loss decision can fall in the same clock. The bench provokes this by corrupting six bits ten bits apart while locked. On the sixth corrupted bit the error pulse and the drop land together, and the bench judges the result by requiring stat_o to stay high for the following twenty bits instead of falling back low. A mode change is also applied in the same cycle as a fresh pattern bit, to confirm that the forced hunt wins over any match or error.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;
  typedef enum logic {PAT_SHORT = 1'b0, PAT_LONG = 1'b1} pat_e;
  typedef enum logic {ST_HUNT = 1'b0, ST_LOCK = 1'b1} lock_st_e;
endpackage

// File: rtl/prbs_tap_sel.sv
module prbs_tap_sel #(
  parameter int LEN = 23,
  parameter int S_A = 15,
  parameter int S_B = 14,
  parameter int L_A = 23,
  parameter int L_B = 18
) (
  input  logic [LEN-1:0] v_i,
  input  logic           long_i,
  output logic           pred_o,
  output logic           nz_o
);
  localparam logic [LEN-1:0] S_MASK = {{(LEN-S_A){1'b0}}, {S_A{1'b1}}};

  // v_i[0] is the newest bit, so v_i[k-1] is the bit k places back
  always_comb begin
    if (long_i) begin
      pred_o = v_i[L_A-1] ^ v_i[L_B-1];
      nz_o   = |v_i;
    end else begin
      pred_o = v_i[S_A-1] ^ v_i[S_B-1];
      nz_o   = |(v_i & S_MASK);
    end
  end
endmodule

// File: rtl/prbs_err_window.sv
module prbs_err_window #(
  parameter int WIN = 64,
  parameter int LIM = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic err_i,
  output logic burst_o
);
  localparam int CW = $clog2(WIN + 1);

  logic [WIN-1:0] eh_q;
  logic [CW-1:0]  cnt_q, cnt_n;

  // sliding count: add the new error, retire the one leaving the window
  assign cnt_n   = cnt_q + CW'(err_i) - CW'(eh_q[WIN-1]);
  assign burst_o = !clr_i && (cnt_n >= CW'(LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      eh_q  <= '0;
      cnt_q <= '0;
    end else begin
      eh_q  <= {eh_q[WIN-2:0], err_i};
      cnt_q <= cnt_n;
    end
  end

  a_r6_count_matches_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(eh_q) == int'(cnt_q));
  a_r6_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= LIM);
endmodule

// File: rtl/prbs_lock_ctrl.sv
module prbs_lock_ctrl
  import prbs_mon_pkg::*;
#(
  parameter int SYNC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic err_i,
  input  logic burst_i,
  input  logic chg_i,
  output logic locked_o,
  output logic load_o,
  output logic stat_o
);
  localparam int MW = $clog2(SYNC + 1);

  lock_st_e      st_q;
  logic [MW-1:0] mcnt_q;
  logic          stat_q;
  logic          run_done;

  assign run_done = match_i && (mcnt_q == MW'(SYNC - 1));
  assign load_o   = (st_q == ST_HUNT) && !chg_i && run_done;
  assign locked_o = (st_q == ST_LOCK);
  assign stat_o   = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      mcnt_q <= '0;
      stat_q <= 1'b1;
    end else if (chg_i) begin
      st_q   <= ST_HUNT;
      mcnt_q <= '0;
      stat_q <= 1'b1;
    end else if (st_q == ST_HUNT) begin
      if (run_done) begin
        st_q   <= ST_LOCK;
        mcnt_q <= '0;
        stat_q <= 1'b0;
      end else begin
        mcnt_q <= match_i ? mcnt_q + MW'(1) : '0;
        stat_q <= 1'b1;
      end
    end else begin
      if (burst_i) begin
        st_q   <= ST_HUNT;
        stat_q <= 1'b1;
      end else begin
        stat_q <= err_i;
      end
    end
  end

  a_r2_lock_after_full_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(mcnt_q) == MW'(SYNC - 1)) && $past(match_i));
  a_r3_high_while_hunting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> stat_o);
  a_r7_mode_change_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |=> !locked_o && stat_o);
  a_r6_burst_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && burst_i) |=> !locked_o);
endmodule

// File: rtl/prbs_lock_mon.sv
module prbs_lock_mon
  import prbs_mon_pkg::*;
#(
  parameter int S_A  = 15,
  parameter int S_B  = 14,
  parameter int L_A  = 23,
  parameter int L_B  = 18,
  parameter int SYNC = 32,
  parameter int WIN  = 64,
  parameter int LIM  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  input  logic rx_bit_i,
  output logic stat_o,
  output logic stat_oe_o
);
  localparam int LEN = L_A;

  pat_e           mode_q;
  logic           chg;
  logic [LEN-1:0] hist_q, hist_n, gen_q;
  logic           hist_pred, hist_nz, gen_pred, gen_nz;
  logic           match, err_raw, err_lk;
  logic           locked, load, burst, oe_q;

  assign chg    = (pat_e'(mode_i) != mode_q);
  assign hist_n = {hist_q[LEN-2:0], rx_bit_i};

  prbs_tap_sel #(.LEN(LEN), .S_A(S_A), .S_B(S_B), .L_A(L_A), .L_B(L_B)) u_hist_tap (
    .v_i(hist_q), .long_i(mode_q == PAT_LONG), .pred_o(hist_pred), .nz_o(hist_nz));

  prbs_tap_sel #(.LEN(LEN), .S_A(S_A), .S_B(S_B), .L_A(L_A), .L_B(L_B)) u_gen_tap (
    .v_i(gen_q), .long_i(mode_q == PAT_LONG), .pred_o(gen_pred), .nz_o(gen_nz));

  // an all-zero history never counts as a match
  assign match   = hist_nz && (rx_bit_i == hist_pred);
  assign err_raw = (rx_bit_i != gen_pred);
  assign err_lk  = locked && err_raw;

  prbs_err_window #(.WIN(WIN), .LIM(LIM)) u_win (
    .clk_i, .rst_ni, .clr_i(!locked || chg), .err_i(err_lk), .burst_o(burst));

  prbs_lock_ctrl #(.SYNC(SYNC)) u_ctrl (
    .clk_i, .rst_ni, .match_i(match), .err_i(err_raw), .burst_i(burst),
    .chg_i(chg), .locked_o(locked), .load_o(load), .stat_o(stat_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PAT_SHORT;
      hist_q <= '0;
      gen_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      mode_q <= pat_e'(mode_i);
      hist_q <= hist_n;
      gen_q  <= load ? hist_n : {gen_q[LEN-2:0], gen_pred};
      oe_q   <= en_i;
    end
  end

  assign stat_oe_o = oe_q;

  a_r8_no_lock_on_zero_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked) |-> $past(hist_nz));
  a_r8_generator_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> gen_nz);
  a_r9_oe_follows_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stat_oe_o == $past(en_i));
endmodule

// File: tb/sim_prbs_lock_mon.sv
`timescale 1ns/1ps
module sim_prbs_lock_mon;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1;
  logic mode_i = 1'b0;
  logic rx_bit_i = 1'b0;
  logic stat_o, stat_oe_o;

  int n_chk = 0;
  int n_err = 0;
  logic [22:0] lf = '1;
  logic        lf_long = 1'b0;

  always #4 clk_i = ~clk_i;

  prbs_lock_mon u0 (.clk_i, .rst_ni, .en_i, .mode_i, .rx_bit_i, .stat_o, .stat_oe_o);

  // {flip, expected stat} walked while locked
  localparam logic [1:0] VEC [16] = '{2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11,
                                      2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00};

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send_raw(input logic b);
    @(negedge clk_i);
    rx_bit_i = b;
    @(posedge clk_i);
    #1;
  endtask

  // pattern bit from the bench's own recurrence
  task automatic send(input logic flip);
    logic nb;
    nb = lf_long ? (lf[22] ^ lf[17]) : (lf[14] ^ lf[13]);
    lf = {lf[21:0], nb};
    send_raw(nb ^ flip);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int bad;
    int lock_at;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10 stat high in reset", stat_o, 1'b1);
    chk("R9 oe low in reset", stat_oe_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R8: all-zero stream
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      send_raw(1'b0);
      if (stat_o !== 1'b1) bad++;
    end
    chk("R8 zeros never lock", bad == 0, 1'b1);
    chk("R9 oe follows enable", stat_oe_o, 1'b1);

    // R1/R2 short pattern acquisition
    bad = 0;
    lock_at = -1;
    for (int i = 1; i <= 80; i++) begin
      send(1'b0);
      if (i <= 31 && stat_o !== 1'b1) bad++;
      if (lock_at < 0 && stat_o === 1'b0) lock_at = i;
    end
    chk("R2 no lock within 31 bits", bad == 0, 1'b1);
    chk("R1 short pattern locks", stat_o, 1'b0);
    chk("R2 lock by bit 48", lock_at >= 32 && lock_at <= 48, 1'b1);

    // R4 clean stream gives no pulse
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      send(1'b0);
      if (stat_o !== 1'b0) bad++;
    end
    chk("R4 no pulse on clean bits", bad == 0, 1'b1);

    // R4 vector table: each flip flagged once
    foreach (VEC[k]) begin
      send(VEC[k][1]);
      chk("R4 single bit flag", stat_o, VEC[k][0]);
    end
    repeat (80) send(1'b0);

    // R5 five errors in a window keep lock
    for (int e = 0; e < 5; e++) begin
      send(1'b1);
      chk("R5 error flagged", stat_o, 1'b1);
      repeat (9) send(1'b0);
    end
    chk("R5 still locked after five", stat_o, 1'b0);
    repeat (80) send(1'b0);

    // R6 six errors in a window: pulse and drop coincide
    for (int e = 0; e < 6; e++) begin
      send(1'b1);
      if (e < 5) repeat (9) send(1'b0);
    end
    chk("R6 sixth error high", stat_o, 1'b1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      send(1'b0);
      if (stat_o !== 1'b1) bad++;
    end
    chk("R6 stays high after drop", bad == 0, 1'b1);
    repeat (60) send(1'b0);
    chk("R11 relock after loss", stat_o, 1'b0);

    // R7 mode change while locked, then long pattern
    mode_i = 1'b1;
    lf = '1;
    lf_long = 1'b1;
    send(1'b0);
    chk("R7 mode change drops lock", stat_o, 1'b1);
    bad = 0;
    for (int i = 1; i <= 70; i++) begin
      send(1'b0);
      if (i <= 31 && stat_o !== 1'b1) bad++;
    end
    chk("R2 long no early lock", bad == 0, 1'b1);
    chk("R1 long pattern locks", stat_o, 1'b0);
    send(1'b1);
    chk("R1 long error flagged", stat_o, 1'b1);
    send(1'b0);
    chk("R4 long flag one clock", stat_o, 1'b0);

    // R9 enable low
    @(negedge clk_i);
    en_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk("R9 oe drops", stat_oe_o, 1'b0);
    @(negedge clk_i);
    en_i = 1'b1;
    @(posedge clk_i);
    #1;
    chk("R9 oe returns", stat_oe_o, 1'b1);

    finish_run();
  end
endmodule